// File: doc/BRIEF.md
# Register Alias Table Renamer

This block sits between decode and scheduling and renames one micro-op per cycle. The micro-op names up to two source registers and one optional destination, all as architectural register numbers. The block looks up the physical register that currently holds each source. When the micro-op writes a register, the block takes a fresh physical register from a sequential allocator and gives it to the destination. It then records that assignment in the mapping table, so that younger micro-ops read the new value. After renaming, only true read-after-write links between micro-ops remain. Two writes to the same architectural register, or a write after a read of it, no longer share storage.

Sources are always looked up before the same micro-op's own destination update takes effect. An instruction such as r1 = r1 - r0 therefore reads the old home of r1 and then moves r1 to a new physical register. The allocator is a two-state machine, `ALLOC_READY` and `ALLOC_EMPTY`. The transition `T_LAST_TAKEN` is taken when the highest physical number is handed out, and the transition `T_RESET` returns the machine to `ALLOC_READY`. In `ALLOC_EMPTY` a micro-op that needs a destination is refused with a stall. Reset restores the identity mapping and restarts the allocator.

Top module: `rat_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i, out_valid and out_stall are low, and the first tag handed out is ARCH_REGS (8 by default).
- R2: A micro-op's source tags come from the mapping as it stood before that micro-op's own destination update, even when a source and the destination name the same architectural register.
- R3: Every accepted micro-op with in_dst_we high receives a new physical tag. Tags are handed out in increasing order, one higher than the previous tag, starting at ARCH_REGS.
- R4: A source that names an architectural register yields the tag most recently given to that register by an accepted micro-op, or the identity tag if no accepted micro-op has written it.
- R5: A micro-op with in_dst_we low consumes no tag and leaves the mapping unchanged, and its out_dst_tag reads 0.
- R6: Once all tags up to PHYS_REGS-1 are handed out, a valid micro-op with in_dst_we high raises out_stall in the same cycle. It is not accepted, and out_valid is low in the next cycle.
- R7: While the allocator is exhausted, a valid micro-op with in_dst_we low is still accepted and renamed.
- R8: Renamed results are registered and appear with out_valid high one cycle after acceptance, with out_dst_we echoing in_dst_we. out_valid is low after a cycle with no valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A micro-op is presented |
| in_src_a | input | $clog2(ARCH_REGS) | First source architectural register |
| in_src_b | input | $clog2(ARCH_REGS) | Second source architectural register |
| in_dst | input | $clog2(ARCH_REGS) | Destination architectural register |
| in_dst_we | input | 1 | Micro-op writes a destination |
| out_stall | output | 1 | Micro-op refused; no physical register left |
| out_valid | output | 1 | Renamed micro-op present |
| out_src_a_tag | output | $clog2(PHYS_REGS) | Physical tag of first source |
| out_src_b_tag | output | $clog2(PHYS_REGS) | Physical tag of second source |
| out_dst_tag | output | $clog2(PHYS_REGS) | New physical tag of destination, 0 if none |
| out_dst_we | output | 1 | Renamed micro-op writes a destination |

## Verification
A directed r1 = r1 - r0 case has a source that names the same register as its destination. It separates a design that reads sources before its own update from one that forwards the new tag early. A following read of r1 then checks that the update has landed. Ops without a destination that are mixed between writes show whether a tag or a mapping leaks when nothing should change. Random mixes of sources, destinations and write flags, checked against a bench model of the table, run the allocator to exhaustion. At that point stalled writers and still-accepted non-writers split the refusal path from the pass path, and a second reset shows that the identity mapping and the first tag come back.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Allocator control states
    typedef enum logic [0:0] {
        ALLOC_READY = 1'b0,
        ALLOC_EMPTY = 1'b1
    } alloc_state_e;

endpackage

// File: rtl/rat_free_alloc.sv
module rat_free_alloc
    import rat_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 32,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic [PW-1:0] free_tag,
    output logic          empty
);

    localparam logic [PW-1:0] FIRST_TAG = PW'(ARCH_REGS);
    localparam logic [PW-1:0] LAST_TAG  = PW'(PHYS_REGS - 1);

    alloc_state_e state_q, state_d;
    logic [PW-1:0] next_q, next_d;

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALLOC_READY;     // T_RESET
            next_q  <= FIRST_TAG;
        end else begin
            state_q <= state_d;
            next_q  <= next_d;
        end
    end

    // Next-state and output logic
    always_comb begin
        state_d  = state_q;
        next_d   = next_q;
        empty    = 1'b0;
        free_tag = next_q;
        unique case (state_q)
            ALLOC_READY: begin
                if (take) begin
                    if (next_q == LAST_TAG) begin
                        state_d = ALLOC_EMPTY;   // T_LAST_TAKEN
                    end else begin
                        next_d = next_q + PW'(1);
                    end
                end
            end
            ALLOC_EMPTY: begin
                empty = 1'b1;
            end
            default: begin
                state_d = ALLOC_READY;
            end
        endcase
    end

endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 32,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [PW-1:0] rd_a_tag,
    output logic [PW-1:0] rd_b_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_tag
);

    logic [PW-1:0] map_q [ARCH_REGS];

    // One entry per architectural register, reset to identity
    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[g] <= PW'(g);
            end else if (wr_en && (wr_idx == AW'(g))) begin
                map_q[g] <= wr_tag;
            end
        end
    end

    // Reads see the table before this cycle's write lands
    always_comb begin
        rd_a_tag = map_q[rd_a_idx];
        rd_b_tag = map_q[rd_b_idx];
    end

endmodule

// File: rtl/rat_renamer.sv
module rat_renamer #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 32,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic [AW-1:0] in_dst,
    input  logic          in_dst_we,
    output logic          out_stall,
    output logic          out_valid,
    output logic [PW-1:0] out_src_a_tag,
    output logic [PW-1:0] out_src_b_tag,
    output logic [PW-1:0] out_dst_tag,
    output logic          out_dst_we
);

    logic          alloc_empty;
    logic [PW-1:0] alloc_tag;
    logic          accept;
    logic          take;
    logic [PW-1:0] look_a, look_b;

    rat_free_alloc #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS)
    ) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .free_tag (alloc_tag),
        .empty    (alloc_empty)
    );

    rat_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (in_src_a),
        .rd_b_idx (in_src_b),
        .rd_a_tag (look_a),
        .rd_b_tag (look_b),
        .wr_en    (take),
        .wr_idx   (in_dst),
        .wr_tag   (alloc_tag)
    );

    always_comb begin
        out_stall = in_valid && in_dst_we && alloc_empty;
        accept    = in_valid && !out_stall;
        take      = accept && in_dst_we;
    end

    // Registered result stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_src_a_tag <= '0;
            out_src_b_tag <= '0;
            out_dst_tag   <= '0;
            out_dst_we    <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_src_a_tag <= look_a;
                out_src_b_tag <= look_b;
                out_dst_tag   <= in_dst_we ? alloc_tag : '0;
                out_dst_we    <= in_dst_we;
            end
        end
    end

endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 32,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_dst_we,
    input logic          out_stall,
    input logic          out_valid,
    input logic [PW-1:0] out_dst_tag,
    input logic          out_dst_we
);

    logic          seen_q;
    logic [PW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (out_valid && out_dst_we) begin
            seen_q <= 1'b1;
            last_q <= out_dst_tag;
        end
    end

    a_r8_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_stall) |=> out_valid);

    a_r8_idle_gives_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall |=> !out_valid);

    a_r7_stall_only_writer: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall |-> (in_valid && in_dst_we));

    a_r3_tag_above_arch: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_we) |-> (out_dst_tag >= PW'(ARCH_REGS)));

    a_r3_tag_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_we && seen_q) |-> (out_dst_tag == last_q + PW'(1)));

    a_r5_no_dest_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dst_we) |-> (out_dst_tag == '0));

endmodule

bind rat_renamer rat_renamer_chk #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_dst_we   (in_dst_we),
    .out_stall   (out_stall),
    .out_valid   (out_valid),
    .out_dst_tag (out_dst_tag),
    .out_dst_we  (out_dst_we)
);

// File: tb/rat_renamer_bench.sv
module rat_renamer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ARCH = 8;
    localparam int PHYS = 32;
    localparam int AW = $clog2(ARCH);
    localparam int PW = $clog2(PHYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_src_a = '0;
    logic [AW-1:0] in_src_b = '0;
    logic [AW-1:0] in_dst = '0;
    logic          in_dst_we = 1'b0;
    logic          out_stall, out_valid, out_dst_we;
    logic [PW-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag;

    int checks = 0;
    int fails = 0;
    int ref_map [ARCH];
    int ref_next;

    always #(CLK_PERIOD/2) clk = ~clk;

    rat_renamer #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u_rat_renamer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_we(in_dst_we),
        .out_stall(out_stall), .out_valid(out_valid),
        .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
        .out_dst_tag(out_dst_tag), .out_dst_we(out_dst_we)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_stall(input bit v, input bit we);
        return v && we && (ref_next >= PHYS);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ARCH; i++) ref_map[i] = i;
        ref_next = ARCH;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 stall after reset", int'(out_stall), 0);
    endtask

    // Drive one micro-op, then check registered result after the edge
    task automatic step(input string req, input bit v, input int a, input int b,
                        input int d, input bit we);
        bit st;
        int ea, eb, ed;
        @(negedge clk);
        in_valid = v; in_src_a = AW'(a); in_src_b = AW'(b);
        in_dst = AW'(d); in_dst_we = we;
        #1;
        st = exp_stall(v, we);
        chk({req, " stall"}, int'(out_stall), int'(st));
        ea = ref_map[a]; eb = ref_map[b]; ed = 0;
        if (v && !st && we) begin
            ed = ref_next;
            ref_map[d] = ref_next;
            ref_next++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        chk({req, " out_valid"}, int'(out_valid), int'(v && !st));
        if (v && !st) begin
            chk({req, " src_a tag"}, int'(out_src_a_tag), ea);
            chk({req, " src_b tag"}, int'(out_src_b_tag), eb);
            chk({req, " dst tag"}, int'(out_dst_tag), ed);
            chk({req, " dst_we"}, int'(out_dst_we), int'(we));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250314));
        model_reset();
        do_reset();
        // R1 identity read with first allocation
        step("R1", 1, 5, 7, 3, 1);
        do_reset();
        // R2: r1 = r1 - r0 reads old r1
        step("R2", 1, 1, 0, 1, 1);
        // R4: later reader sees new r1
        step("R4", 1, 1, 1, 2, 1);
        // R5: no destination, no tag used
        step("R5", 1, 1, 2, 1, 0);
        step("R5 follow", 1, 1, 2, 4, 1);
        // R8: idle cycle
        step("R8 idle", 0, 0, 0, 0, 1);
        // R3/R4 random mix until exhaustion and beyond
        for (int n = 0; n < 60; n++) begin
            step("R3 R4 random", ($urandom % 8) != 0, $urandom % ARCH,
                 $urandom % ARCH, $urandom % ARCH, ($urandom % 4) != 0);
        end
        while (ref_next < PHYS) step("R3 fill", 1, 0, 1, 2, 1);
        // R6: writer refused when exhausted
        step("R6", 1, 3, 4, 5, 1);
        step("R6 again", 1, 2, 2, 2, 1);
        // R7: non-writer still passes, map unchanged by refused writers
        step("R7", 1, 2, 5, 0, 0);
        // R1: reset restores identity and first tag
        do_reset();
        step("R1 restart", 1, 2, 6, 6, 1);
        step("R1 second", 1, 6, 3, 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule